// File: doc/BRIEF.md
# E1 Transmit Spare and International Bit Inserter

This block sits in the transmit path of an E1 framer. It fills in the spare (Sa4 to Sa8) and international (Si) bit positions of timeslot 0. All other bits of the outgoing serial stream pass through unchanged. The block has its own bit and frame position counter. The counter covers one double frame: an even frame, which carries the alignment word, and an odd frame, which carries the non-alignment word. Each frame is `FRAME_BITS` bits long and one bit is handled per clock.

Each spare bit has its own source select. It is taken either from a host field or from an external link input. A link clock output tells external logic when to present link data. The Si bit is chosen by a priority scheme. From highest to lowest:
1. The serial data input.
2. An override value that comes from checksum or remote-error logic.
3. The host field.

The host fields are copied into shadow storage once per double frame. A transmit-align status pulse marks each copy. A host write made in the middle of a double frame therefore takes effect only in the next one. If the host writes nothing, the old values are sent again.

Spare bits can be passed through transparently. To do this, select the link input for all five spare bits and feed the serial data back as link data.

Top module: `e1_sasi_inserter`

## Requirements
- R1: The output `ser_o` equals `ser_i` delayed by one clock for every position except Si and the five spare slots. This covers all bits outside timeslot 0 and the fixed alignment and non-alignment bits.
- R2: Bit k of `sa_link_sel_i` corresponds to spare bit Sa(4+k), at bit index 3+k of the odd frame. When that select bit is 1, `ser_o` carries `link_i` from that position, one clock later.
- R3: When the select bit of a spare slot is 0, that slot carries bit k of the shadowed spare field.
- R4: When `si_from_reg_i` is 0, the Si position (bit index 0 of every frame) carries `ser_i`. This holds whatever the values of `crc4_mode_i` and `ebit_auto_i`.
- R5: When `si_from_reg_i` is 1 and either `crc4_mode_i` or `ebit_auto_i` is 1, the Si position carries `si_override_i`.
- R6: When `si_from_reg_i` is 1 and neither mode is on, Si carries a shadowed field. In the even frame this is the shadowed align Si field; in the odd frame it is the shadowed non-align Si field.
- R7: The shadow fields are loaded from the host fields only on the clock that ends the last bit of the odd frame. A host write at any other time first appears in the next double frame. Unchanged fields are sent again in every double frame.
- R8: `taf_o` is high for exactly one clock, at bit 0 of the even frame, after each shadow load. It stays low during the first double frame after reset.
- R9: `link_clk_o` is high during exactly those cycles whose position is a spare slot selected for link sourcing. `link_i` is sampled at the end of that cycle.
- R10: While reset is low, `ser_o`, `link_clk_o` and `taf_o` are 0 and the shadow fields clear. The first cycle after reset is bit 0 of the even frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial transmit data in |
| link_i | input | 1 | External spare-bit link data |
| align_si_i | input | 1 | Host Si field for the even frame |
| nalign_si_i | input | 1 | Host Si field for the odd frame |
| sa_word_i | input | 5 | Host spare field, bit k = Sa(4+k) |
| sa_link_sel_i | input | 5 | Per-spare source select, 1 = link |
| si_from_reg_i | input | 1 | 1 = Si from host field or override, 0 = from ser_i |
| crc4_mode_i | input | 1 | Checksum multiframe mode enable |
| ebit_auto_i | input | 1 | Automatic remote-error bit enable |
| si_override_i | input | 1 | Si value from checksum or remote-error logic |
| ser_o | output | 1 | Merged serial transmit data out |
| link_clk_o | output | 1 | High while a link-sourced spare slot is current |
| taf_o | output | 1 | One-cycle pulse after each shadow load |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a double frame. The bench must show that the old shadow value is still sent for the rest of that double frame and that the new value appears only after the next load. To get there, the stimulus follows the bench's own position count and changes the host fields at a fixed offset inside a double frame. It then holds the fields steady for a whole further double frame, so that the retransmission case is also covered. The Si priority layers are reached by switching the mode bits one at a time while the override and serial data stay random.

// File: rtl/e1_sasi_pkg.sv
package e1_sasi_pkg;

    // Timeslot-0 geometry of an E1 frame
    localparam int TS0_WIDTH     = 8;
    localparam int SI_SLOT       = 0;
    localparam int SA_FIRST_SLOT = 3;
    localparam int SA_COUNT      = 5;

    // Source of the bit placed on the output
    typedef enum logic [1:0] {
        SRC_SERIAL   = 2'd0,
        SRC_LINK     = 2'd1,
        SRC_SHADOW   = 2'd2,
        SRC_OVERRIDE = 2'd3
    } bit_src_e;

endpackage

// File: rtl/e1_sasi_poscnt.sv
module e1_sasi_poscnt #(
    parameter int FRAME_BITS = 256,
    parameter int DF_FRAMES  = 2,
    localparam int BIT_W     = $clog2(FRAME_BITS),
    localparam int FRM_W     = (DF_FRAMES > 1) ? $clog2(DF_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [BIT_W-1:0] bit_idx_o,
    output logic [FRM_W-1:0] frame_idx_o,
    output logic [BIT_W-1:0] nxt_bit_idx_o,
    output logic [FRM_W-1:0] nxt_frame_idx_o,
    output logic             df_last_o
);

    typedef struct packed {
        logic [BIT_W-1:0] bit_idx;
        logic [FRM_W-1:0] frame_idx;
    } pos_t;

    pos_t pos_d, pos_q;
    logic bit_wrap, frame_wrap;

    always_comb begin
        pos_d      = pos_q;
        bit_wrap   = (pos_q.bit_idx == BIT_W'(FRAME_BITS - 1));
        frame_wrap = (pos_q.frame_idx == FRM_W'(DF_FRAMES - 1));
        if (bit_wrap) begin
            pos_d.bit_idx   = '0;
            pos_d.frame_idx = frame_wrap ? '0 : pos_q.frame_idx + 1'b1;
        end else begin
            pos_d.bit_idx = pos_q.bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_idx_o       = pos_q.bit_idx;
    assign frame_idx_o     = pos_q.frame_idx;
    assign nxt_bit_idx_o   = pos_d.bit_idx;
    assign nxt_frame_idx_o = pos_d.frame_idx;
    assign df_last_o       = bit_wrap && frame_wrap;

    AST_DF_RESTART: assert property (@(posedge clk) disable iff (!rst_n) df_last_o |=> (bit_idx_o == '0 && frame_idx_o == '0)) else $error("double frame did not restart"); // R10

endmodule

// File: rtl/e1_sasi_shadow.sv
module e1_sasi_shadow
    import e1_sasi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                align_si_i,
    input  logic                nalign_si_i,
    input  logic [SA_COUNT-1:0] sa_word_i,
    output logic                align_si_o,
    output logic                nalign_si_o,
    output logic [SA_COUNT-1:0] sa_word_o,
    output logic                taf_o
);

    typedef struct packed {
        logic                align_si;
        logic                nalign_si;
        logic [SA_COUNT-1:0] sa;
        logic                taf;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.taf = load_i;
        if (load_i) begin
            st_d.align_si  = align_si_i;
            st_d.nalign_si = nalign_si_i;
            st_d.sa        = sa_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign align_si_o  = st_q.align_si;
    assign nalign_si_o = st_q.nalign_si;
    assign sa_word_o   = st_q.sa;
    assign taf_o       = st_q.taf;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load_i |=> $stable({align_si_o, nalign_si_o, sa_word_o})) else $error("shadow changed without load"); // R7
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> (sa_word_o == $past(sa_word_i))) else $error("shadow missed load"); // R7
    AST_TAF_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> taf_o) else $error("no status pulse after load"); // R8
    AST_TAF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) taf_o |=> !taf_o) else $error("status pulse too long"); // R8

endmodule

// File: rtl/e1_sasi_merge.sv
module e1_sasi_merge
    import e1_sasi_pkg::*;
#(
    parameter int BIT_W = 8,
    parameter int FRM_W = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BIT_W-1:0]    bit_idx_i,
    input  logic [FRM_W-1:0]    frame_idx_i,
    input  logic [BIT_W-1:0]    nxt_bit_idx_i,
    input  logic [FRM_W-1:0]    nxt_frame_idx_i,
    input  logic                ser_i,
    input  logic                link_i,
    input  logic [SA_COUNT-1:0] sa_link_sel_i,
    input  logic                si_from_reg_i,
    input  logic                crc4_mode_i,
    input  logic                ebit_auto_i,
    input  logic                si_override_i,
    input  logic                align_si_sh_i,
    input  logic                nalign_si_sh_i,
    input  logic [SA_COUNT-1:0] sa_sh_i,
    output logic                ser_o,
    output logic                link_clk_o
);

    typedef struct packed {
        logic ser;
        logic lclk;
    } out_t;

    out_t st_d, st_q;

    logic [SA_COUNT-1:0] sa_hit, sa_hit_nxt;
    logic                si_hit, sa_any, sa_from_link, sa_shadow_bit, shadow_bit;
    bit_src_e            src;

    // one decoder per spare slot, for the current and the following position
    for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa_slot
        localparam int SLOT = SA_FIRST_SLOT + k;
        assign sa_hit[k]     = frame_idx_i[0] && (bit_idx_i == BIT_W'(SLOT));
        assign sa_hit_nxt[k] = nxt_frame_idx_i[0] && (nxt_bit_idx_i == BIT_W'(SLOT));
    end

    always_comb begin
        si_hit        = (bit_idx_i == BIT_W'(SI_SLOT));
        sa_any        = |sa_hit;
        sa_from_link  = |(sa_hit & sa_link_sel_i);
        sa_shadow_bit = |(sa_hit & sa_sh_i);
        shadow_bit    = si_hit ? (frame_idx_i[0] ? nalign_si_sh_i : align_si_sh_i)
                               : sa_shadow_bit;

        // Si priority: serial input, then override, then shadow field
        src = SRC_SERIAL;
        if (si_hit) begin
            if (!si_from_reg_i)                  src = SRC_SERIAL;
            else if (crc4_mode_i || ebit_auto_i) src = SRC_OVERRIDE;
            else                                 src = SRC_SHADOW;
        end else if (sa_any) begin
            src = sa_from_link ? SRC_LINK : SRC_SHADOW;
        end

        st_d = st_q;
        unique case (src)
            SRC_SERIAL:   st_d.ser = ser_i;
            SRC_LINK:     st_d.ser = link_i;
            SRC_SHADOW:   st_d.ser = shadow_bit;
            SRC_OVERRIDE: st_d.ser = si_override_i;
            default:      st_d.ser = ser_i;
        endcase

        // link clock is high while the link-sourced slot is current
        st_d.lclk = |(sa_hit_nxt & sa_link_sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o      = st_q.ser;
    assign link_clk_o = st_q.lclk;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (!si_hit && !sa_any) |=> (ser_o == $past(ser_i))) else $error("pass-through bit altered"); // R1
    AST_SA_LINK: assert property (@(posedge clk) disable iff (!rst_n) sa_from_link |=> (ser_o == $past(link_i))) else $error("link spare bit wrong"); // R2
    AST_SI_SERIAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (si_hit && !si_from_reg_i) |=> (ser_o == $past(ser_i))) else $error("Si serial source lost"); // R4
    AST_SI_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n) (si_hit && si_from_reg_i && (crc4_mode_i || ebit_auto_i)) |=> (ser_o == $past(si_override_i))) else $error("Si override lost"); // R5
    AST_LCLK_ON_SA: assert property (@(posedge clk) disable iff (!rst_n) link_clk_o |-> sa_any) else $error("link clock outside spare slot"); // R9

endmodule

// File: rtl/e1_sasi_inserter.sv
module e1_sasi_inserter
    import e1_sasi_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int DF_FRAMES  = 2,
    localparam int BIT_W     = $clog2(FRAME_BITS),
    localparam int FRM_W     = (DF_FRAMES > 1) ? $clog2(DF_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_i,
    input  logic                link_i,
    input  logic                align_si_i,
    input  logic                nalign_si_i,
    input  logic [SA_COUNT-1:0] sa_word_i,
    input  logic [SA_COUNT-1:0] sa_link_sel_i,
    input  logic                si_from_reg_i,
    input  logic                crc4_mode_i,
    input  logic                ebit_auto_i,
    input  logic                si_override_i,
    output logic                ser_o,
    output logic                link_clk_o,
    output logic                taf_o
);

    logic [BIT_W-1:0]    bit_idx, nxt_bit_idx;
    logic [FRM_W-1:0]    frame_idx, nxt_frame_idx;
    logic                df_last;
    logic                align_si_sh, nalign_si_sh;
    logic [SA_COUNT-1:0] sa_sh;

    e1_sasi_poscnt #(
        .FRAME_BITS (FRAME_BITS),
        .DF_FRAMES  (DF_FRAMES)
    ) u_poscnt (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_idx_o       (bit_idx),
        .frame_idx_o     (frame_idx),
        .nxt_bit_idx_o   (nxt_bit_idx),
        .nxt_frame_idx_o (nxt_frame_idx),
        .df_last_o       (df_last)
    );

    e1_sasi_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (df_last),
        .align_si_i  (align_si_i),
        .nalign_si_i (nalign_si_i),
        .sa_word_i   (sa_word_i),
        .align_si_o  (align_si_sh),
        .nalign_si_o (nalign_si_sh),
        .sa_word_o   (sa_sh),
        .taf_o       (taf_o)
    );

    e1_sasi_merge #(
        .BIT_W (BIT_W),
        .FRM_W (FRM_W)
    ) u_merge (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_idx_i       (bit_idx),
        .frame_idx_i     (frame_idx),
        .nxt_bit_idx_i   (nxt_bit_idx),
        .nxt_frame_idx_i (nxt_frame_idx),
        .ser_i           (ser_i),
        .link_i          (link_i),
        .sa_link_sel_i   (sa_link_sel_i),
        .si_from_reg_i   (si_from_reg_i),
        .crc4_mode_i     (crc4_mode_i),
        .ebit_auto_i     (ebit_auto_i),
        .si_override_i   (si_override_i),
        .align_si_sh_i   (align_si_sh),
        .nalign_si_sh_i  (nalign_si_sh),
        .sa_sh_i         (sa_sh),
        .ser_o           (ser_o),
        .link_clk_o      (link_clk_o)
    );

    AST_TAF_NOT_ON_SA: assert property (@(posedge clk) disable iff (!rst_n) taf_o |-> !link_clk_o) else $error("status pulse overlaps link clock"); // R8

endmodule

// File: tb/tb_e1_sasi_inserter.sv
module tb_e1_sasi_inserter;

    localparam int FB = 256;
    localparam int DF = 2 * FB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_i = 1'b0, link_i = 1'b0;
    logic       align_si_i = 1'b0, nalign_si_i = 1'b0;
    logic [4:0] sa_word_i = 5'd0, sa_link_sel_i = 5'd0;
    logic       si_from_reg_i = 1'b1, crc4_mode_i = 1'b0, ebit_auto_i = 1'b0;
    logic       si_override_i = 1'b0;
    logic       ser_o, link_clk_o, taf_o;

    e1_sasi_inserter dut (
        .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .link_i(link_i),
        .align_si_i(align_si_i), .nalign_si_i(nalign_si_i), .sa_word_i(sa_word_i),
        .sa_link_sel_i(sa_link_sel_i), .si_from_reg_i(si_from_reg_i),
        .crc4_mode_i(crc4_mode_i), .ebit_auto_i(ebit_auto_i),
        .si_override_i(si_override_i), .ser_o(ser_o), .link_clk_o(link_clk_o), .taf_o(taf_o)
    );

    always #5 clk = ~clk;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    bit  loop_mode = 1'b0;
    bit  started = 1'b0;

    // behavioural reference: position integer and shadow copies
    int         m_pos;
    logic       m_align_si, m_nalign_si;
    logic [4:0] m_sa;
    logic       m_ser, m_lclk, m_taf;
    string      m_tag;

    always @(posedge clk) begin
        int b, f, nb, nf;
        started = 1'b1;
        if (!rst_n) begin
            m_pos = 0; m_align_si = 0; m_nalign_si = 0; m_sa = 0;
            m_ser = 0; m_lclk = 0; m_taf = 0; m_tag = "R10";
        end else begin
            b = m_pos % FB;
            f = (m_pos / FB) % 2;
            if (b == 0) begin
                if (!si_from_reg_i) begin
                    m_ser = ser_i; m_tag = "R4";
                end else if (crc4_mode_i || ebit_auto_i) begin
                    m_ser = si_override_i; m_tag = "R5";
                end else begin
                    m_ser = (f == 1) ? m_nalign_si : m_align_si;
                    m_tag = (m_ser !== ((f == 1) ? nalign_si_i : align_si_i)) ? "R7" : "R6";
                end
            end else if (f == 1 && b >= 3 && b <= 7) begin
                if (sa_link_sel_i[b-3]) begin
                    m_ser = link_i; m_tag = "R2";
                end else begin
                    m_ser = m_sa[b-3];
                    m_tag = (m_sa[b-3] !== sa_word_i[b-3]) ? "R7" : "R3";
                end
            end else begin
                m_ser = ser_i; m_tag = "R1";
            end
            m_taf = (m_pos == DF - 1);
            if (m_taf) begin
                m_align_si = align_si_i; m_nalign_si = nalign_si_i; m_sa = sa_word_i;
            end
            m_pos = (m_pos + 1) % DF;
            nb = m_pos % FB;
            nf = (m_pos / FB) % 2;
            m_lclk = (nf == 1 && nb >= 3 && nb <= 7) ? sa_link_sel_i[nb-3] : 1'b0;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b pos=%0d t=%0t", tag, what, act, exp, m_pos, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            if (!rst_n) begin
                check(ser_o, 1'b0, "R10", "ser_o in reset");
                check(link_clk_o, 1'b0, "R10", "link_clk_o in reset");
                check(taf_o, 1'b0, "R10", "taf_o in reset");
            end else begin
                check(ser_o, m_ser, m_tag, "ser_o");
                check(link_clk_o, m_lclk, "R9", "link_clk_o");
                check(taf_o, m_taf, "R8", "taf_o");
            end
        end
    end

    // random data streams
    always @(negedge clk) begin
        ser_i         = 1'($urandom_range(0, 1));
        link_i        = loop_mode ? ser_i : 1'($urandom_range(0, 1));
        si_override_i = 1'($urandom_range(0, 1));
    end

    task automatic run_df(input int n);
        repeat (n * DF) @(negedge clk);
    endtask

    task automatic wait_pos(input int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    task automatic new_fields();
        align_si_i  = 1'($urandom_range(0, 1));
        nalign_si_i = 1'($urandom_range(0, 1));
        sa_word_i   = 5'($urandom_range(0, 31));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        @(posedge clk); #1 rst_n = 1'b1;
        // R8: no status pulse in the first double frame, R3/R6 with cleared shadow
        sa_word_i = 5'b10110; align_si_i = 1'b1; nalign_si_i = 1'b0;
        run_df(2);
        // R3 / R6 with all spare bits from the host field, several values
        for (int i = 0; i < 3; i++) begin
            new_fields();
            run_df(1);
        end
        // R7: mid-double-frame write, then one unchanged double frame
        wait_pos(100);
        sa_word_i = ~sa_word_i; align_si_i = ~align_si_i; nalign_si_i = ~nalign_si_i;
        run_df(2);
        // R2 / R9: spare select patterns
        sa_link_sel_i = 5'b11111; run_df(2);
        sa_link_sel_i = 5'b10110; new_fields(); run_df(2);
        sa_link_sel_i = 5'b01001; new_fields(); run_df(2);
        // R5: override layers
        crc4_mode_i = 1'b1; run_df(2);
        crc4_mode_i = 1'b0; ebit_auto_i = 1'b1; run_df(2);
        // R4: serial source beats both modes
        crc4_mode_i = 1'b1; si_from_reg_i = 1'b0; run_df(2);
        ebit_auto_i = 1'b0; crc4_mode_i = 1'b0; run_df(1);
        // R2: transparent spare path via loop-back
        si_from_reg_i = 1'b1; sa_link_sel_i = 5'b11111; loop_mode = 1'b1; run_df(2);
        loop_mode = 1'b0; sa_link_sel_i = 5'b00000;
        // R10: reset in mid-stream, then restart at position 0
        wait_pos(300);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        @(posedge clk); #1 rst_n = 1'b1;
        new_fields();
        run_df(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule